// File: doc/BRIEF.md
# Float to Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer whose width is set by a parameter (32 or 64 bits). The operand comes in already split into a class code, a sign, a signed unbiased exponent, a left-aligned mantissa and a sticky bit. The block rounds the fraction with one of four directed modes, saturates values that do not fit, and reports four exception flags alongside the result.

A caller presents one operand with a one-cycle valid strobe. One clock later the integer and its flags appear on registered outputs with a matching valid pulse. The outputs then hold until the next strobe. A truncate input lets an instruction that always chops toward zero share the unit with instructions that follow the current rounding mode.

Top module: `fti_top`

## Requirements
- R1: A conversion strobed by `in_valid` in one cycle shows its result and flags on the outputs after the next rising clock edge, with `out_valid` high for exactly that one cycle. When `in_valid` is low the result and flags hold their values. Synchronous reset clears every output to 0.
- R2: Class code 0 (zero) yields result 0 with all four flags clear, whatever the sign. The class codes are 0 zero, 1 finite number, 2 infinity, 3 quiet NaN and 4 signalling NaN.
- R3: A finite number has a value of `in_mant` / 2^(MANT_W-1) * 2^`in_exp`, so the mantissa MSB carries weight 2^exp. When the guard bit and the round/sticky term are both zero, the exact integer is returned: a positive value as is, a negative one as the two's complement of its magnitude. No flag is raised.
- R4: Mode code 0 (nearest-even) increments the truncated magnitude when the guard bit (the highest discarded bit) is set and either the OR of the lower discarded bits and `in_sticky` is nonzero or the truncated integer is odd.
- R5: Mode code 1 (toward zero) never increments. Mode code 2 (toward plus infinity) increments an inexact magnitude only for a positive operand. Mode code 3 (toward minus infinity) increments only for a negative operand.
- R6: Any nonzero discarded bit or sticky sets `out_inexact`. `out_rounded` is set only when the magnitude was incremented.
- R7: When `force_trunc` is high, rounding is toward zero, whatever `rnd_mode` holds.
- R8: An infinity, or a finite number with exponent >= INT_W, overflows. The result is 2^(INT_W-1)-1 for a positive sign and -2^(INT_W-1) for a negative one. `out_invalid` is set, and `out_inexact` and `out_rounded` are cleared.
- R9: A rounded magnitude of at least 2^(INT_W-1) + sign is an overflow as in R8. So -2^(INT_W-1) is a valid result for a negative operand, while +2^(INT_W-1) saturates, even when it is reached only by rounding.
- R10: Every NaN (codes 3 and 4, with codes 5 to 7 treated as quiet NaN) is an overflow with its sign forced negative, giving -2^(INT_W-1) and `out_invalid`. Code 4 also sets `out_snan`. No other case sets `out_snan`.
- R11: Exponents below zero follow the same rounding rules. At exponent -1 the mantissa MSB is the guard bit. Below -1 the guard is 0 and every mantissa bit feeds the round/sticky term.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| in_cls | input | 3 | Operand class code |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EXP_W | Signed unbiased exponent |
| in_mant | input | MANT_W | Left-aligned mantissa, MSB weight 2^exp |
| in_sticky | input | 1 | OR of mantissa bits below the LSB |
| rnd_mode | input | 2 | Rounding mode code |
| force_trunc | input | 1 | Force toward-zero rounding |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | INT_W | Signed integer result |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_rounded | output | 1 | Magnitude was incremented |
| out_invalid | output | 1 | Overflow, infinity or NaN conversion |
| out_snan | output | 1 | Operand was a signalling NaN |

## Verification
A wrong shift amount or guard-bit pick in the alignment stage shows up as an off-by-power-of-two result or a misplaced tie decision on the very next output strobe. The tests therefore use small values whose exact and tie cases are known. A wrong overflow limit shows only at the edges: either +2^31 escapes saturation or -2^31 is wrongly clamped. Both edges are driven directly and also reached by rounding. A flag path that is not cleared on overflow leaves `out_inexact` or `out_rounded` high next to `out_invalid` in the same cycle.

// File: rtl/fti_pkg.sv
package fti_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_NUM  = 3'd1,
    CLS_INF  = 3'd2,
    CLS_QNAN = 3'd3,
    CLS_SNAN = 3'd4
  } fti_cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } fti_rm_e;

  typedef struct packed {
    logic inexact;
    logic rounded;
    logic invalid;
    logic snan;
  } fti_flags_t;

endpackage

// File: rtl/fti_align.sv
// Places the integer part of the operand in an INT_W-bit field and extracts
// the guard bit and the round/sticky term from the discarded fraction.
module fti_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 53,
  parameter int EXP_W  = 12
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  input  logic                     sticky_i,
  output logic        [INT_W-1:0]  int_o,
  output logic                     guard_o,
  output logic                     rs_o,
  output logic                     big_o
);
  localparam int VW   = INT_W + MANT_W;
  localparam int SH_W = $clog2(INT_W + 1);

  logic [VW-1:0]   wide;
  logic [SH_W-1:0] shamt;
  logic            tiny;

  always_comb begin
    big_o  = (exp_i >= INT_W);
    tiny   = (exp_i < -1);
    shamt  = SH_W'(exp_i) + SH_W'(1);
    wide   = {{INT_W{1'b0}}, mant_i};
    if (!big_o && !tiny) begin
      wide = wide << shamt;
    end
    if (tiny) begin
      int_o   = '0;
      guard_o = 1'b0;
      rs_o    = (|mant_i) | sticky_i;
    end else if (big_o) begin
      int_o   = '0;
      guard_o = 1'b0;
      rs_o    = 1'b0;
    end else begin
      int_o   = wide[VW-1:MANT_W];
      guard_o = wide[MANT_W-1];
      rs_o    = (|wide[MANT_W-2:0]) | sticky_i;
    end
  end
endmodule

// File: rtl/fti_round.sv
// Decides the increment for the selected mode and forms the rounded magnitude.
module fti_round
  import fti_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] int_i,
  input  logic             guard_i,
  input  logic             rs_i,
  input  logic             sign_i,
  input  fti_rm_e          mode_i,
  output logic [INT_W:0]   mag_o,
  output logic             inexact_o,
  output logic             rounded_o
);
  logic bump;

  always_comb begin
    inexact_o = guard_i | rs_i;
    unique case (mode_i)
      RM_NEAR: bump = guard_i & (rs_i | int_i[0]);
      RM_ZERO: bump = 1'b0;
      RM_UP:   bump = inexact_o & ~sign_i;
      RM_DOWN: bump = inexact_o & sign_i;
      default: bump = 1'b0;
    endcase
    rounded_o = bump;
    mag_o     = {1'b0, int_i} + {{INT_W{1'b0}}, bump};
  end
endmodule

// File: rtl/fti_sat.sv
// Applies class handling, the overflow limit, saturation and the sign.
module fti_sat
  import fti_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic [2:0]       cls_i,
  input  logic             sign_i,
  input  logic             big_i,
  input  logic [INT_W:0]   mag_i,
  input  logic             inexact_i,
  input  logic             rounded_i,
  output logic [INT_W-1:0] result_o,
  output fti_flags_t       flags_o
);
  logic [INT_W:0]   limit;
  logic             ovf;
  logic             ovf_sign;
  logic [INT_W-1:0] low;

  always_comb begin
    limit    = {2'b01, {(INT_W-1){1'b0}}} + {{INT_W{1'b0}}, sign_i};
    low      = mag_i[INT_W-1:0];
    ovf      = 1'b0;
    ovf_sign = sign_i;
    flags_o  = '0;
    result_o = '0;
    unique case (cls_i)
      CLS_ZERO: ovf = 1'b0;
      CLS_NUM: begin
        ovf = big_i || (mag_i >= limit);
        if (!ovf) begin
          result_o        = sign_i ? (~low + 1'b1) : low;
          flags_o.inexact = inexact_i;
          flags_o.rounded = rounded_i;
        end
      end
      CLS_INF: ovf = 1'b1;
      CLS_SNAN: begin
        ovf          = 1'b1;
        ovf_sign     = 1'b1;
        flags_o.snan = 1'b1;
      end
      default: begin
        ovf      = 1'b1;
        ovf_sign = 1'b1;
      end
    endcase
    if (ovf) begin
      result_o        = {ovf_sign, {(INT_W-1){~ovf_sign}}};
      flags_o.invalid = 1'b1;
      flags_o.inexact = 1'b0;
      flags_o.rounded = 1'b0;
    end
  end
endmodule

// File: rtl/fti_top.sv
module fti_top
  import fti_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 53,
  parameter int EXP_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_cls,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0] in_mant,
  input  logic              in_sticky,
  input  logic [1:0]        rnd_mode,
  input  logic              force_trunc,
  output logic              out_valid,
  output logic [INT_W-1:0]  out_result,
  output logic              out_inexact,
  output logic              out_rounded,
  output logic              out_invalid,
  output logic              out_snan
);
  localparam logic [INT_W-1:0] MAX_POS = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] MIN_NEG = {1'b1, {(INT_W-1){1'b0}}};

  logic [INT_W-1:0] int_part;
  logic             guard, rs, big;
  logic [INT_W:0]   mag;
  logic             rnd_inexact, rnd_rounded;
  logic [INT_W-1:0] res_d;
  fti_flags_t       flags_d;
  fti_rm_e          mode_eff;

  assign mode_eff = force_trunc ? RM_ZERO : fti_rm_e'(rnd_mode);

  fti_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i    ($signed(in_exp)),
    .mant_i   (in_mant),
    .sticky_i (in_sticky),
    .int_o    (int_part),
    .guard_o  (guard),
    .rs_o     (rs),
    .big_o    (big)
  );

  fti_round #(.INT_W(INT_W)) u_round (
    .int_i     (int_part),
    .guard_i   (guard),
    .rs_i      (rs),
    .sign_i    (in_sign),
    .mode_i    (mode_eff),
    .mag_o     (mag),
    .inexact_o (rnd_inexact),
    .rounded_o (rnd_rounded)
  );

  fti_sat #(.INT_W(INT_W)) u_sat (
    .cls_i     (in_cls),
    .sign_i    (in_sign),
    .big_i     (big),
    .mag_i     (mag),
    .inexact_i (rnd_inexact),
    .rounded_i (rnd_rounded),
    .result_o  (res_d),
    .flags_o   (flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_inexact <= 1'b0;
      out_rounded <= 1'b0;
      out_invalid <= 1'b0;
      out_snan    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= res_d;
        out_inexact <= flags_d.inexact;
        out_rounded <= flags_d.rounded;
        out_invalid <= flags_d.invalid;
        out_snan    <= flags_d.snan;
      end
    end
  end

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R1
  hold_res_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid)));
  // R2
  zero_res_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls == 3'd0) |=>
      (out_result == '0 && !out_inexact && !out_rounded && !out_invalid && !out_snan));
  // R6
  rounded_imp_chk: assert property (@(posedge clk) disable iff (rst)
    out_rounded |-> out_inexact);
  // R7
  trunc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && force_trunc) |=> !out_rounded);
  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (!out_inexact && !out_rounded &&
                     (out_result == MAX_POS || out_result == MIN_NEG)));
  // R10
  nan_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_cls >= 3'd3) |=> (out_invalid && out_result == MIN_NEG));
  // R10
  snan_only_chk: assert property (@(posedge clk) disable iff (rst)
    out_snan |-> out_invalid);
endmodule

// File: tb/test_fti_top.sv
`timescale 1ns/1ps
module test_fti_top;
  localparam int INT_W = 32, MANT_W = 53, EXP_W = 12;
  localparam logic [MANT_W-1:0] M1_0  = 53'h10000000000000;
  localparam logic [MANT_W-1:0] M1_125 = 53'h12000000000000;
  localparam logic [MANT_W-1:0] M1_25 = 53'h14000000000000;
  localparam logic [MANT_W-1:0] M1_375 = 53'h16000000000000;
  localparam logic [MANT_W-1:0] M1_5  = 53'h18000000000000;
  localparam logic [MANT_W-1:0] M1_75 = 53'h1C000000000000;
  localparam logic [MANT_W-1:0] MNEAR2 = 53'h1FFFFFFFE00000;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_sign = 1'b0, in_sticky = 1'b0, force_trunc = 1'b0;
  logic [2:0] in_cls = '0;
  logic [EXP_W-1:0] in_exp = '0;
  logic [MANT_W-1:0] in_mant = '0;
  logic [1:0] rnd_mode = '0;
  logic out_valid, out_inexact, out_rounded, out_invalid, out_snan;
  logic [INT_W-1:0] out_result;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fti_top #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_fti_top (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_cls(in_cls), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .in_sticky(in_sticky), .rnd_mode(rnd_mode),
    .force_trunc(force_trunc), .out_valid(out_valid), .out_result(out_result),
    .out_inexact(out_inexact), .out_rounded(out_rounded), .out_invalid(out_invalid),
    .out_snan(out_snan));

  // flags order: {inexact, rounded, invalid, snan}
  task automatic chk(input string tag, input logic [31:0] er, input logic [3:0] ef);
    logic [3:0] af;
    af = {out_inexact, out_rounded, out_invalid, out_snan};
    checks++;
    if (out_result !== er || af !== ef || out_valid !== 1'b1) begin
      fails++;
      $display("FAIL %s: result=%h flags=%b valid=%b expected result=%h flags=%b valid=1",
               tag, out_result, af, out_valid, er, ef);
    end
  endtask

  task automatic conv(input logic [2:0] c, input logic s, input int e,
                      input logic [MANT_W-1:0] m, input logic st,
                      input logic [1:0] rm, input logic tr);
    @(negedge clk);
    in_cls = c; in_sign = s; in_exp = EXP_W'(e); in_mant = m; in_sticky = st;
    rnd_mode = rm; force_trunc = tr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    checks++;
    if (out_valid !== 1'b0 || out_result !== '0 ||
        {out_inexact, out_rounded, out_invalid, out_snan} !== 4'b0) begin
      fails++;
      $display("FAIL R1 reset: valid=%b result=%h expected 0/0", out_valid, out_result);
    end
  endtask

  task automatic t_zero();
    conv(3'd0, 1'b1, 5, M1_5, 1'b1, 2'd3, 1'b0); chk("R2 neg zero", 32'h0, 4'b0000);
  endtask

  task automatic t_exact();
    conv(3'd1, 1'b0, 2, M1_25, 1'b0, 2'd0, 1'b0); chk("R3 +5", 32'd5, 4'b0000);
    conv(3'd1, 1'b1, 2, M1_25, 1'b0, 2'd2, 1'b0); chk("R3 -5", 32'hFFFFFFFB, 4'b0000);
  endtask

  task automatic t_nearest();
    conv(3'd1, 1'b0, 1, M1_25, 1'b0, 2'd0, 1'b0); chk("R4 tie even 2.5", 32'd2, 4'b1000);
    conv(3'd1, 1'b0, 1, M1_75, 1'b0, 2'd0, 1'b0); chk("R4 tie odd 3.5", 32'd4, 4'b1100);
    conv(3'd1, 1'b0, 1, M1_25, 1'b1, 2'd0, 1'b0); chk("R4 sticky 2.5+", 32'd3, 4'b1100);
    conv(3'd1, 1'b1, 1, M1_375, 1'b0, 2'd0, 1'b0); chk("R4 -2.75", 32'hFFFFFFFD, 4'b1100);
  endtask

  task automatic t_directed();
    conv(3'd1, 1'b0, 1, M1_125, 1'b0, 2'd2, 1'b0); chk("R5 up +2.25", 32'd3, 4'b1100);
    conv(3'd1, 1'b0, 1, M1_125, 1'b0, 2'd3, 1'b0); chk("R5 down +2.25", 32'd2, 4'b1000);
    conv(3'd1, 1'b0, 1, M1_125, 1'b0, 2'd1, 1'b0); chk("R5 zero +2.25", 32'd2, 4'b1000);
    conv(3'd1, 1'b1, 1, M1_125, 1'b0, 2'd3, 1'b0); chk("R5 down -2.25", 32'hFFFFFFFD, 4'b1100);
    conv(3'd1, 1'b1, 1, M1_125, 1'b0, 2'd2, 1'b0); chk("R5 up -2.25", 32'hFFFFFFFE, 4'b1000);
  endtask

  task automatic t_trunc();
    conv(3'd1, 1'b0, 1, M1_75, 1'b0, 2'd0, 1'b1); chk("R7 trunc near 3.5", 32'd3, 4'b1000);
    conv(3'd1, 1'b0, 1, M1_75, 1'b0, 2'd2, 1'b1); chk("R7 trunc up 3.5", 32'd3, 4'b1000);
    conv(3'd1, 1'b1, 1, M1_75, 1'b0, 2'd3, 1'b1); chk("R7 trunc down -3.5", 32'hFFFFFFFD, 4'b1000);
  endtask

  task automatic t_small();
    conv(3'd1, 1'b0, -1, M1_5, 1'b0, 2'd0, 1'b0); chk("R11 0.75", 32'd1, 4'b1100);
    conv(3'd1, 1'b0, -1, M1_0, 1'b0, 2'd0, 1'b0); chk("R11 0.5 tie", 32'd0, 4'b1000);
    conv(3'd1, 1'b0, -40, M1_0, 1'b0, 2'd2, 1'b0); chk("R11 tiny up", 32'd1, 4'b1100);
    conv(3'd1, 1'b0, -40, M1_0, 1'b0, 2'd0, 1'b0); chk("R11 tiny near", 32'd0, 4'b1000);
    conv(3'd1, 1'b1, -2, M1_0, 1'b0, 2'd3, 1'b0); chk("R11 -0.25 down", 32'hFFFFFFFF, 4'b1100);
  endtask

  task automatic t_overflow();
    conv(3'd2, 1'b0, 0, '0, 1'b0, 2'd0, 1'b0); chk("R8 +inf", 32'h7FFFFFFF, 4'b0010);
    conv(3'd2, 1'b1, 0, '0, 1'b0, 2'd0, 1'b0); chk("R8 -inf", 32'h80000000, 4'b0010);
    conv(3'd1, 1'b0, 32, M1_5, 1'b1, 2'd0, 1'b0); chk("R8 exp 32", 32'h7FFFFFFF, 4'b0010);
    conv(3'd1, 1'b1, 40, M1_0, 1'b0, 2'd0, 1'b0); chk("R8 exp 40 neg", 32'h80000000, 4'b0010);
  endtask

  task automatic t_limit();
    conv(3'd1, 1'b1, 31, M1_0, 1'b0, 2'd0, 1'b0); chk("R9 -2^31 exact", 32'h80000000, 4'b0000);
    conv(3'd1, 1'b0, 31, M1_0, 1'b0, 2'd0, 1'b0); chk("R9 +2^31", 32'h7FFFFFFF, 4'b0010);
    conv(3'd1, 1'b0, 30, MNEAR2, 1'b0, 2'd0, 1'b0); chk("R9 round to +2^31", 32'h7FFFFFFF, 4'b0010);
    conv(3'd1, 1'b1, 30, MNEAR2, 1'b0, 2'd0, 1'b0); chk("R9 round to -2^31", 32'h80000000, 4'b1100);
    conv(3'd1, 1'b0, 30, MNEAR2, 1'b0, 2'd1, 1'b0); chk("R9 trunc below", 32'h7FFFFFFF, 4'b1000);
  endtask

  task automatic t_nan();
    conv(3'd4, 1'b0, 0, M1_5, 1'b0, 2'd0, 1'b0); chk("R10 snan", 32'h80000000, 4'b0011);
    conv(3'd3, 1'b0, 0, M1_5, 1'b0, 2'd0, 1'b0); chk("R10 qnan", 32'h80000000, 4'b0010);
    conv(3'd6, 1'b0, 0, M1_5, 1'b0, 2'd0, 1'b0); chk("R10 code 6", 32'h80000000, 4'b0010);
  endtask

  task automatic t_hold();
    conv(3'd1, 1'b0, 2, M1_25, 1'b0, 2'd0, 1'b0); chk("R1 load 5", 32'd5, 4'b0000);
    @(negedge clk);
    in_cls = 3'd2; in_exp = EXP_W'(3);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_result !== 32'd5 || out_invalid !== 1'b0) begin
      fails++;
      $display("FAIL R1 hold: valid=%b result=%h inv=%b expected 0/00000005/0",
               out_valid, out_result, out_invalid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_zero();
    t_exact();
    t_nearest();
    t_directed();
    t_trunc();
    t_small();
    t_overflow();
    t_limit();
    t_nan();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule